// File: doc/BRIEF.md
# Branch and Subroutine Address Unit

This unit produces the next program address for a processor whose addresses are 20 bits wide and whose instructions sit on word boundaries. The pipelined program counter runs six bytes past the first word of the instruction that is executing. A sequencer hands the unit one control-flow operation per transfer. Each transfer carries the operation class, a condition flag, both displacement fields, an absolute target, the value popped off the stack for a return, and the current program address, which is the instruction's first word plus 6. The unit returns the new program address and a flag saying whether that address must be loaded. For the three call forms it also returns the value to push.

The return-address handling is deliberately asymmetric. A short call, which is one word long, subtracts 2 from the program address before pushing it. Long calls and absolute jump-to-subroutine push the address unchanged. A return always subtracts 2 from the popped value. With this arrangement a single return instruction resumes correctly after both one-word and two-word calls.

Both the request side and the result side use valid/ready handshakes. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result shows up on `out_valid` in the following cycle. While `out_ready` is low, the result holds steady and `in_ready` falls, so back-pressure passes straight through to the request side with no loss and no duplication.

Top module: `branch_addr_unit`

## Requirements
- R1: Operation code 0 (short branch) with `in_taken` high yields `out_load`=1 and `out_target` = `in_pc` + sign-extended `in_disp_s`, modulo 2^20, with no push.
- R2: Operation code 1 (long branch) with `in_taken` high yields `out_load`=1 and `out_target` = `in_pc` + sign-extended `in_disp_l`, modulo 2^20, wrapping across the 4-bit bank field.
- R3: Bit 0 of any displacement is cleared before it is added, so an odd displacement rounds down to the next lower even value. For example, -1 acts as -2.
- R4: A branch (code 0 or 1) with `in_taken` low yields `out_load`=0, `out_target` = `in_pc`, and no push.
- R5: Operation code 2 (short call) yields `out_load`=1, target `in_pc` + even sign-extended `in_disp_s`, and push value `in_pc` - 2. `in_taken` is ignored.
- R6: Operation code 3 (long call) yields `out_load`=1, target `in_pc` + even sign-extended `in_disp_l`, and push value `in_pc` unchanged.
- R7: Operation code 4 (absolute jump-to-subroutine) yields `out_load`=1, target `in_abs`, and push value `in_pc`.
- R8: Operation code 5 (return) yields `out_load`=1, target `in_pop` - 2 modulo 2^20, and no push.
- R9: `out_push` is high only in the single cycle in which a result from codes 2, 3 or 4 transfers (`out_valid` and `out_ready` both high), so each call gives exactly one push pulse.
- R10: After reset `out_valid` is 0. `in_ready` equals `!out_valid || out_ready`. A result that is not accepted keeps `out_valid`, `out_target` and `out_load` unchanged.
- R11: Operation codes 6 and 7 yield `out_load`=0, `out_target` = `in_pc`, and no push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 3 | Operation class, codes 0..5 as in the requirements |
| in_taken | input | 1 | Branch condition result |
| in_disp_s | input | 8 | Short displacement |
| in_disp_l | input | 16 | Long displacement |
| in_abs | input | 20 | Absolute call target |
| in_pop | input | 20 | Value popped from the stack for a return |
| in_pc | input | 20 | Current program address (first word plus 6) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_load | output | 1 | New address must be loaded |
| out_target | output | 20 | New program address |
| out_push | output | 1 | Push strobe, one cycle per call at transfer |
| out_push_val | output | 20 | Return value to push |

## Verification
The hardest case to reach is a call result that waits under back-pressure while the next request is already waiting at the input. In that case the push strobe has to stay low through every stalled cycle, rise exactly once in the transfer cycle, and the queued request must neither overwrite nor duplicate the held result. The stimulus reaches this by driving `out_ready` from a random stall pattern while requests, many of them calls, are presented back to back. Separate directed vectors cover the wrap across the bank field in both directions and the odd negative displacements.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic [2:0] {
    OP_BR_SHORT   = 3'd0,
    OP_BR_LONG    = 3'd1,
    OP_CALL_SHORT = 3'd2,
    OP_CALL_LONG  = 3'd3,
    OP_CALL_ABS   = 3'd4,
    OP_RETURN     = 3'd5
  } op_e;

  localparam int unsigned OP_W = 3;
endpackage

// File: rtl/bsa_disp_align.sv
// Sign-extends a displacement to address width and forces it even.
module bsa_disp_align #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 20
) (
  input  logic [IN_W-1:0]  disp,
  output logic [OUT_W-1:0] ext
);
  localparam int unsigned PAD_W = (OUT_W > IN_W) ? (OUT_W - IN_W) : 0;

  generate
    if (PAD_W > 0) begin : g_extend
      assign ext = {{PAD_W{disp[IN_W-1]}}, disp[IN_W-1:1], 1'b0};
    end else begin : g_trunc
      assign ext = {disp[OUT_W-1:1], 1'b0};
    end
  endgenerate
endmodule

// File: rtl/bsa_target_calc.sv
// Combinational target and return-address arithmetic.
module bsa_target_calc
  import bsa_pkg::*;
#(
  parameter int unsigned AW      = 20,
  parameter int unsigned SDISP_W = 8,
  parameter int unsigned LDISP_W = 16,
  parameter int unsigned RET_ADJ = 2
) (
  input  logic [OP_W-1:0]    op,
  input  logic               taken,
  input  logic [SDISP_W-1:0] disp_s,
  input  logic [LDISP_W-1:0] disp_l,
  input  logic [AW-1:0]      abs_tgt,
  input  logic [AW-1:0]      pop_val,
  input  logic [AW-1:0]      pc,
  output logic               load,
  output logic [AW-1:0]      target,
  output logic               push,
  output logic [AW-1:0]      push_val
);
  localparam logic [AW-1:0] ADJ = AW'(RET_ADJ);

  logic [AW-1:0] off_s, off_l;
  logic [AW-1:0] sum_s, sum_l;
  op_e           opc;

  bsa_disp_align #(.IN_W(SDISP_W), .OUT_W(AW)) u_align_s (.disp(disp_s), .ext(off_s));
  bsa_disp_align #(.IN_W(LDISP_W), .OUT_W(AW)) u_align_l (.disp(disp_l), .ext(off_l));

  assign opc   = op_e'(op);
  assign sum_s = pc + off_s;
  assign sum_l = pc + off_l;

  always_comb begin
    load     = 1'b0;
    target   = pc;
    push     = 1'b0;
    push_val = pc;
    case (opc)
      OP_BR_SHORT: begin
        load   = taken;
        target = taken ? sum_s : pc;
      end
      OP_BR_LONG: begin
        load   = taken;
        target = taken ? sum_l : pc;
      end
      OP_CALL_SHORT: begin
        load     = 1'b1;
        target   = sum_s;
        push     = 1'b1;
        push_val = pc - ADJ;
      end
      OP_CALL_LONG: begin
        load     = 1'b1;
        target   = sum_l;
        push     = 1'b1;
      end
      OP_CALL_ABS: begin
        load     = 1'b1;
        target   = abs_tgt;
        push     = 1'b1;
      end
      OP_RETURN: begin
        load   = 1'b1;
        target = pop_val - ADJ;
      end
      default: begin
        load = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bsa_out_stage.sv
// Single result register with valid/ready handshake.
module bsa_out_stage #(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          d_load,
  input  logic [AW-1:0] d_target,
  input  logic          d_push,
  input  logic [AW-1:0] d_push_val,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_load,
  output logic [AW-1:0] out_target,
  output logic          out_push,
  output logic [AW-1:0] out_push_val
);
  logic push_q;
  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_load     <= 1'b0;
      out_target   <= '0;
      push_q       <= 1'b0;
      out_push_val <= '0;
    end else begin
      if (accept) begin
        out_valid    <= 1'b1;
        out_load     <= d_load;
        out_target   <= d_target;
        push_q       <= d_push;
        out_push_val <= d_push_val;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_push = out_valid && out_ready && push_q;
endmodule

// File: rtl/branch_addr_unit.sv
module branch_addr_unit
  import bsa_pkg::*;
#(
  parameter int unsigned AW      = 20,
  parameter int unsigned SDISP_W = 8,
  parameter int unsigned LDISP_W = 16,
  parameter int unsigned RET_ADJ = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OP_W-1:0]    in_op,
  input  logic               in_taken,
  input  logic [SDISP_W-1:0] in_disp_s,
  input  logic [LDISP_W-1:0] in_disp_l,
  input  logic [AW-1:0]      in_abs,
  input  logic [AW-1:0]      in_pop,
  input  logic [AW-1:0]      in_pc,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_load,
  output logic [AW-1:0]      out_target,
  output logic               out_push,
  output logic [AW-1:0]      out_push_val
);
  logic          c_load, c_push;
  logic [AW-1:0] c_target, c_push_val;

  bsa_target_calc #(
    .AW(AW), .SDISP_W(SDISP_W), .LDISP_W(LDISP_W), .RET_ADJ(RET_ADJ)
  ) u_calc (
    .op(in_op), .taken(in_taken), .disp_s(in_disp_s), .disp_l(in_disp_l),
    .abs_tgt(in_abs), .pop_val(in_pop), .pc(in_pc),
    .load(c_load), .target(c_target), .push(c_push), .push_val(c_push_val)
  );

  bsa_out_stage #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .d_load(c_load), .d_target(c_target), .d_push(c_push), .d_push_val(c_push_val),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_load(out_load), .out_target(out_target),
    .out_push(out_push), .out_push_val(out_push_val)
  );
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int unsigned AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_op,
  input logic          in_taken,
  input logic [AW-1:0] in_abs,
  input logic [AW-1:0] in_pop,
  input logic [AW-1:0] in_pc,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_load,
  input logic [AW-1:0] out_target,
  input logic          out_push,
  input logic [AW-1:0] out_push_val
);
  logic [2:0]    sh_op;
  logic          sh_taken;
  logic [AW-1:0] sh_abs, sh_pop, sh_pc;
  logic          sh_call;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_op    <= 3'd7;
      sh_taken <= 1'b0;
      sh_abs   <= '0;
      sh_pop   <= '0;
      sh_pc    <= '0;
    end else if (in_valid && in_ready) begin
      sh_op    <= in_op;
      sh_taken <= in_taken;
      sh_abs   <= in_abs;
      sh_pop   <= in_pop;
      sh_pc    <= in_pc;
    end
  end

  assign sh_call = (sh_op == 3'd2) || (sh_op == 3'd3) || (sh_op == 3'd4);

  assert_push_on_transfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> (out_valid && out_ready && sh_call));

  assert_return_adjust_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sh_op == 3'd5) |-> (out_load && !out_push && out_target == sh_pop - AW'(2)));

  assert_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sh_op <= 3'd1 && !sh_taken) |-> (!out_load && out_target == sh_pc));

  assert_abs_call_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sh_op == 3'd4) |-> (out_load && out_target == sh_abs && out_push_val == sh_pc));

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_target) && $stable(out_load)));

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind branch_addr_unit bsa_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_taken(in_taken), .in_abs(in_abs), .in_pop(in_pop),
  .in_pc(in_pc), .out_valid(out_valid), .out_ready(out_ready),
  .out_load(out_load), .out_target(out_target), .out_push(out_push),
  .out_push_val(out_push_val)
);

// File: tb/branch_addr_unit_test.sv
module branch_addr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic        in_taken = 1'b0;
  logic [7:0]  in_disp_s = '0;
  logic [15:0] in_disp_l = '0;
  logic [19:0] in_abs = '0;
  logic [19:0] in_pop = '0;
  logic [19:0] in_pc = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_load;
  logic [19:0] out_target;
  logic        out_push;
  logic [19:0] out_push_val;

  int checks = 0;
  int fails = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  logic [41:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_taken(in_taken), .in_disp_s(in_disp_s),
    .in_disp_l(in_disp_l), .in_abs(in_abs), .in_pop(in_pop), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_load(out_load),
    .out_target(out_target), .out_push(out_push), .out_push_val(out_push_val)
  );

  // Behavioural model: {load, push, target, push_val}
  function automatic logic [41:0] model(int op, bit tk, int ds, int dl, int ab, int pp, int pc);
    int s, l, tgt, pv;
    bit ld, pu;
    s = (ds >= 128) ? ds - 256 : ds;
    l = (dl >= 32768) ? dl - 65536 : dl;
    s = s & ~1;
    l = l & ~1;
    ld = 0; pu = 0; tgt = pc; pv = pc;
    case (op)
      0: begin ld = tk; if (tk) tgt = pc + s; end
      1: begin ld = tk; if (tk) tgt = pc + l; end
      2: begin ld = 1; pu = 1; tgt = pc + s; pv = pc - 2; end
      3: begin ld = 1; pu = 1; tgt = pc + l; end
      4: begin ld = 1; pu = 1; tgt = ab; end
      5: begin ld = 1; tgt = pp - 2; end
      default: ;
    endcase
    return {ld, pu, 20'(tgt & 'hFFFFF), 20'(pv & 'hFFFFF)};
  endfunction

  function automatic string tag_of(int op, bit tk);
    case (op)
      0: return tk ? "R1/R3" : "R4";
      1: return tk ? "R2/R3" : "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R11";
    endcase
  endfunction

  string tagq[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare against the model at every falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check(in_ready == (!out_valid || out_ready), "R10", "in_ready", in_ready, !out_valid || out_ready);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R10", "unexpected result", 1, 0);
        end else begin
          logic [41:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(out_load == e[41], t, "load", out_load, e[41]);
          check(out_target == e[39:20], t, "target", out_target, e[39:20]);
          check(out_push == e[40], "R9", "push", out_push, e[40]);
          if (e[40]) check(out_push_val == e[19:0], t, "push_val", out_push_val, e[19:0]);
        end
      end else begin
        check(out_push == 1'b0, "R9", "push outside transfer", out_push, 0);
      end
      if (in_valid && in_ready) begin
        expq.push_back(model(in_op, in_taken, in_disp_s, in_disp_l, in_abs, in_pop, in_pc));
        tagq.push_back(tag_of(in_op, in_taken));
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready <= stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic send(int op, bit tk, int ds, int dl, int ab, int pp, int pc);
    in_op = 3'(op); in_taken = tk; in_disp_s = 8'(ds); in_disp_l = 16'(dl);
    in_abs = 20'(ab); in_pop = 20'(pp); in_pc = 20'(pc);
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "reset out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R10", "reset in_ready", in_ready, 1);
    @(posedge clk); #1;
    // R1 short taken, R3 odd and negative odd
    send(0, 1, 'h10, 0, 0, 0, 'h00106);
    send(0, 1, 'h11, 0, 0, 0, 'h00106);
    send(0, 1, 'hFF, 0, 0, 0, 'h00106);
    // R2 bank crossing up and wrap down
    send(1, 1, 0, 'h0010, 0, 0, 'h0FFFA);
    send(1, 1, 0, 'hFFF0, 0, 0, 'h00004);
    send(1, 1, 0, 'h7FFF, 0, 0, 'hFFFF0);
    // R4 not taken
    send(0, 0, 'h40, 0, 0, 0, 'h12346);
    send(1, 0, 0, 'h1234, 0, 0, 'h12346);
    // R5 short call, taken ignored
    send(2, 0, 'h80, 0, 0, 0, 'h20008);
    // R6, R7
    send(3, 1, 0, 'h8001, 0, 0, 'h30006);
    send(4, 0, 0, 0, 'hABCDE, 0, 'h40006);
    // R8 return with wrap
    send(5, 0, 0, 0, 0, 'h00000, 'h50006);
    send(5, 1, 0, 0, 0, 'h20006, 'h50006);
    // R11 unused codes
    send(6, 1, 'h10, 'h10, 'h11111, 'h22222, 'h60006);
    send(7, 1, 'h10, 'h10, 'h11111, 'h22222, 'h70006);
    // R9/R10 random traffic under back-pressure
    stall_mode = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      send($urandom_range(0, 7), 1'($urandom), $urandom_range(0, 255),
           $urandom_range(0, 65535), $urandom_range(0, 'hFFFFF),
           $urandom_range(0, 'hFFFFF), $urandom_range(0, 'hFFFFF));
    end
    stall_mode = 1'b0;
    repeat (10) @(posedge clk);
    check(expq.size() == 0, "R10", "results drained", expq.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule